// File: doc/BRIEF.md
# Double-Buffered Nibble DAC Input Register

This block is the digital front end of a 12-bit parallel-input converter, modelled synchronously in one system clock domain. A host with a 4-bit or 8-bit data path writes a 12-bit code over an 8-bit bus. The code goes into three 4-bit input latches, each selected by two address lines. An active-low chip select and an active-low write strobe qualify each write. A second 12-bit stage, the DAC register, drives the output code. Under an active-low load control it takes all three input latches together, so the output never shows a partly written code.

While load is held high, the host may fill the input latches in any order, and the output holds its value. While load is held low, the DAC register follows the input latches. It keeps their value from load's rising edge onward. A host may load the code as three nibble writes, or as one byte write (low and middle nibbles) followed by one nibble write (high nibble). When load is kept low in the byte-plus-nibble scheme, the high nibble must be written last.

An active-low clear zeroes both stages. A sticky flag reports a load pulse that was too short: load was low when a write committed, and it was then released before a programmable minimum number of clocks.

Top module: `nibble_dac_inreg`

## Requirements
- R1: Address code {addr[1],addr[0]} = 01 writes the low nibble (code bits 3:0) from bus bits 3:0, and touches no other latch.
- R2: Address code 10 writes the middle nibble (code bits 7:4) from bus bits 7:4. Address code 11 writes the high nibble (code bits 11:8) from bus bits 7:4.
- R3: Address code 00 writes the low nibble from bus bits 3:0 and the middle nibble from bus bits 7:4 in the same write.
- R4: A write commits on the clock edge where wr_n is sampled high after it was sampled low on the previous edge, provided cs_n was sampled low on that previous edge. Address and data are those sampled on the previous edge. A strobe with cs_n high writes nothing.
- R5: While ld_n is sampled high, and was also sampled high on the previous edge, dac_code does not change, whatever writes occur.
- R6: On each edge where ld_n is sampled low, and on the first edge where it is sampled high again, dac_code takes all 12 bits of the input latches as they stood before that edge. After that edge it holds them.
- R7: On an edge where clr_n is sampled low, all input latches and dac_code become zero. This takes priority over a write or a load on the same edge.
- R8: If a write commits on an edge where ld_n is sampled low, and ld_n then rises after being sampled low on fewer than LD_MIN consecutive edges, hold_viol sets. A load pulse with no write committed during it never sets hold_viol.
- R9: Once set, hold_viol stays set until rst_n is asserted. clr_n does not clear it.
- R10: After rst_n is asserted, dac_code is zero and hold_viol is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d | input | 2*NIB (8) | Host data bus |
| addr | input | 2 | Latch select |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| ld_n | input | 1 | Active-low load of the DAC register |
| clr_n | input | 1 | Active-low synchronous clear of both stages |
| dac_code | output | 3*NIB (12) | DAC register contents |
| hold_viol | output | 1 | Sticky short-load flag |

## Verification
The embedded assertions check the cycle-level rules on every cycle:
- the output holds while load stays high;
- the output follows the latches one edge later while load is low;
- clear empties the output on the next edge;
- the input latches change only on a committed write;
- the violation flag is sticky and rises only just after a load release.

The directed scenarios are needed to show the address decoding with real bus values. They also show:
- the fill orders of the two loading schemes;
- that a strobe with chip select high is ignored;
- clear winning over a write on the same edge;
- the difference between a short load pulse with no write and one that overlaps a committed write.

// File: rtl/nibble_dac_inreg.sv
module nibble_dac_inreg #(
  parameter int NIB    = 4,
  parameter int LD_MIN = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*NIB-1:0]   bus_d,
  input  logic [1:0]         addr,
  input  logic               cs_n,
  input  logic               wr_n,
  input  logic               ld_n,
  input  logic               clr_n,
  output logic [3*NIB-1:0]   dac_code,
  output logic               hold_viol
);
  localparam int BW = 2*NIB;
  localparam int CW = 3*NIB;
  localparam int TW = $clog2(LD_MIN+1);
  localparam logic [TW-1:0] TMAX = TW'(LD_MIN);

  logic          wr_s, cs_s, ld_s;
  logic [BW-1:0] d_s;
  logic [1:0]    a_s;
  logic [NIB-1:0] lo_q, mid_q, hi_q;
  logic [CW-1:0] dac_q;
  logic [TW-1:0] ld_cnt;
  logic          armed, viol_q;

  wire wr_rise = wr_n & ~wr_s;
  wire commit  = wr_rise & ~cs_s;
  wire ld_rise = ld_n & ~ld_s;
  wire [CW-1:0] latches = {hi_q, mid_q, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_s <= 1'b1;
      cs_s <= 1'b1;
      ld_s <= 1'b1;
      d_s  <= '0;
      a_s  <= '0;
    end else begin
      wr_s <= wr_n;
      cs_s <= cs_n;
      ld_s <= ld_n;
      d_s  <= bus_d;
      a_s  <= addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      mid_q <= '0;
      hi_q  <= '0;
    end else if (!clr_n) begin
      lo_q  <= '0;
      mid_q <= '0;
      hi_q  <= '0;
    end else if (commit) begin
      case (a_s)
        2'b00: begin
          lo_q  <= d_s[NIB-1:0];
          mid_q <= d_s[BW-1:NIB];
        end
        2'b01: lo_q  <= d_s[NIB-1:0];
        2'b10: mid_q <= d_s[BW-1:NIB];
        default: hi_q <= d_s[BW-1:NIB];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                dac_q <= '0;
    else if (!clr_n)           dac_q <= '0;
    else if (!ld_n || ld_rise) dac_q <= latches;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_cnt <= '0;
      armed  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      if (!ld_n) begin
        if (ld_cnt != TMAX) ld_cnt <= ld_cnt + 1'b1;
        if (commit) armed <= 1'b1;
      end else begin
        ld_cnt <= '0;
        armed  <= 1'b0;
      end
      if (ld_rise && armed && ld_cnt < TMAX) viol_q <= 1'b1;
    end
  end

  assign dac_code  = dac_q;
  assign hold_viol = viol_q;

  // R5
  ld_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n && ld_s && clr_n) |=> $stable(dac_code));

  // R6
  ld_low_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && clr_n) |=> (dac_code == $past(latches)));

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (dac_code == '0 && latches == '0));

  // R4
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !commit) |=> $stable(latches));

  // R9
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_viol |=> hold_viol);

  // R8
  viol_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_viol) |-> ($past(ld_n) && !$past(ld_s)));
endmodule

// File: tb/nibble_dac_inreg_tb_top.sv
module nibble_dac_inreg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_d = '0;
  logic [1:0]  addr = '0;
  logic        cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
  logic [11:0] dac_code;
  logic        hold_viol;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nibble_dac_inreg #(.NIB(4), .LD_MIN(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .addr(addr), .cs_n(cs_n),
    .wr_n(wr_n), .ld_n(ld_n), .clr_n(clr_n), .dac_code(dac_code),
    .hold_viol(hold_viol));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%03h expected=0x%03h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
    @(negedge clk);
    addr = a; bus_d = d; cs_n = sel_n; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; bus_d = 8'h5A; addr = ~a;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic load_pulse(input int n);
    @(negedge clk);
    ld_n = 1'b0;
    step(n);
    ld_n = 1'b1;
    step(2);
  endtask

  task automatic t_reset;
    chk("R10 dac", dac_code, 12'h000);
    chk("R10 viol", {11'd0, hold_viol}, 12'h000);
  endtask

  task automatic t_three_nibbles;
    host_write(2'b11, 8'hC0, 1'b0);
    host_write(2'b01, 8'h0A, 1'b0);
    host_write(2'b10, 8'hB0, 1'b0);
    step(1);
    chk("R5 held during writes", dac_code, 12'h000);
    load_pulse(6);
    chk("R1 R2 R6 three nibble load", dac_code, 12'hCBA);
    chk("R8 no write in pulse", {11'd0, hold_viol}, 12'h000);
  endtask

  task automatic t_byte_then_nibble;
    @(negedge clk);
    ld_n = 1'b0;
    host_write(2'b00, 8'h65, 1'b0);
    step(1);
    chk("R3 R6 byte while transparent", dac_code, 12'hC65);
    host_write(2'b11, 8'h70, 1'b0);
    step(1);
    chk("R2 R6 high nibble last", dac_code, 12'h765);
    step(6);
    ld_n = 1'b1;
    step(2);
    chk("R6 held after release", dac_code, 12'h765);
    chk("R8 long pulse no flag", {11'd0, hold_viol}, 12'h000);
  endtask

  task automatic t_host_4bit;
    host_write(2'b01, 8'h33, 1'b0);
    host_write(2'b10, 8'h99, 1'b0);
    host_write(2'b11, 8'hEE, 1'b0);
    step(1);
    chk("R5 stable in 4-bit mode", dac_code, 12'h765);
    load_pulse(6);
    chk("R1 R2 4-bit host", dac_code, 12'hE93);
  endtask

  task automatic t_cs_ignored;
    host_write(2'b01, 8'hFF, 1'b1);
    host_write(2'b11, 8'h00, 1'b1);
    load_pulse(2);
    chk("R4 cs high ignored", dac_code, 12'hE93);
    chk("R8 short pulse no write", {11'd0, hold_viol}, 12'h000);
  endtask

  task automatic t_clear;
    @(negedge clk);
    addr = 2'b11; bus_d = 8'h50; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; clr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; clr_n = 1'b1;
    chk("R7 clear output", dac_code, 12'h000);
    load_pulse(6);
    chk("R7 clear beats write", dac_code, 12'h000);
  endtask

  task automatic t_violation;
    @(negedge clk);
    ld_n = 1'b0;
    @(negedge clk);
    addr = 2'b01; bus_d = 8'h0F; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; ld_n = 1'b1;
    step(2);
    chk("R8 short load after write", {11'd0, hold_viol}, 12'h001);
    chk("R6 value on release", dac_code, 12'h00F);
    load_pulse(8);
    @(negedge clk);
    clr_n = 1'b0;
    @(negedge clk);
    clr_n = 1'b1;
    step(1);
    chk("R9 flag sticky", {11'd0, hold_viol}, 12'h001);
    chk("R7 clear after violation", dac_code, 12'h000);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_three_nibbles();
    t_byte_then_nibble();
    t_host_4bit();
    t_cs_ignored();
    t_clear();
    t_violation();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule